// File: doc/BRIEF.md
# Three-Frame Dither Colour Modulator

This block sits between the frame store and the column drivers of a two-colour emissive panel. Each stored pixel is a 4-bit code: the upper two bits give the red sub-pixel level and the lower two bits give the green sub-pixel level. The panel can only switch a sub-pixel fully on or fully off. The block therefore turns each 2-bit level into an on/off decision that depends on where the internal scan stands in a repeating cycle of three panel frames. Over one cycle, level 0 lights in no frame, level 1 in one frame, level 2 in two frames and level 3 in all three.

The scan logic pulses `frame_go` once at the start of every internal panel frame. This pulse advances a modulo-3 phase counter. It runs asynchronously to any incoming video, so the block keeps no tie to the video frame rate. While the panel is blanked with `blank`, both drive bits are held off. The phase counter keeps stepping during blanking, so the dither sequence picks up where it left off when blanking ends.

Top module: `tri_dither`

## Requirements
- R1: During and right after reset, `red_drv`, `grn_drv` and `drv_valid` are 0, and the phase counter starts at phase 0.
- R2: `drv_valid` equals the value `pix_valid` had one clock earlier.
- R3: The red level is taken from `pix_code[3:2]` and the green level from `pix_code[1:0]`. Level 2'b11 gives a drive bit of 1 in every phase. Level 2'b00 gives 0 in every phase. For example, code 12 lights red only, code 3 lights green only and code 15 lights both.
- R4: Level 2'b01 gives a drive bit of 1 only when the phase is 0.
- R5: Level 2'b10 gives a drive bit of 1 when the phase is 1 or 2, and 0 when the phase is 0.
- R6: Each `frame_go` pulse moves the phase 0→1→2→0. Over three consecutive frames, level 2'b01 is lit in exactly one frame and level 2'b10 in exactly two.
- R7: When `blank` is high in the cycle a pixel is presented, both drive bits for that pixel are 0. `drv_valid` is still 1.
- R8: `frame_go` pulses that arrive while `blank` is high still advance the phase.
- R9: When `pix_valid` is low, both drive bits are 0 one cycle later, whatever `pix_code` holds.
- R10: A pixel presented in the same cycle as `frame_go` is modulated with the phase in force before that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Panel scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_code | input | CODE_W (4) | Pixel code, red level in upper half, green level in lower half |
| pix_valid | input | 1 | Qualifies pix_code in this cycle |
| frame_go | input | 1 | One-cycle pulse at the start of each internal panel frame |
| blank | input | 1 | Forces both drive bits off |
| red_drv | output | 1 | Red sub-pixel drive bit |
| grn_drv | output | 1 | Green sub-pixel drive bit |
| drv_valid | output | 1 | Qualifies red_drv and grn_drv |

## Verification
Every result of this block is due exactly one clock after its inputs are sampled. The drive bits and `drv_valid` come out of one register stage. A `frame_go` pulse affects only pixels presented in later cycles. The bench drives each input set on a falling edge and updates its behavioural phase model at the next rising edge, using the pre-pulse phase for the pixel of that cycle. It then compares all three outputs one time unit after that edge, so each comparison sees the registered response to exactly one input set. Dedicated frame-by-frame tallies confirm the one-in-three and two-in-three lit counts, including across a blanking stretch.

// File: rtl/tri_dither.sv
module tri_dither #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] pix_code,
  input  logic              pix_valid,
  input  logic              frame_go,
  input  logic              blank,
  output logic              red_drv,
  output logic              grn_drv,
  output logic              drv_valid
);
  localparam int LVL_W  = CODE_W / 2;
  localparam int PERIOD = 3;
  localparam int PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0]  phase;
  logic [LVL_W-1:0] red_lvl, grn_lvl;
  logic             red_lit, grn_lit;

  assign red_lvl = pix_code[CODE_W-1 -: LVL_W];
  assign grn_lvl = pix_code[LVL_W-1:0];

  function automatic logic lit(input logic [LVL_W-1:0] lvl, input logic [PH_W-1:0] ph);
    unique case (lvl)
      2'b00:   lit = 1'b0;
      2'b01:   lit = (ph == '0);
      2'b10:   lit = (ph != '0);
      default: lit = 1'b1;
    endcase
  endfunction

  assign red_lit = lit(red_lvl, phase);
  assign grn_lit = lit(grn_lvl, phase);

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= '0;
    else if (frame_go)
      phase <= (phase == PH_W'(PERIOD - 1)) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red_drv   <= 1'b0;
      grn_drv   <= 1'b0;
      drv_valid <= 1'b0;
    end else begin
      red_drv   <= pix_valid && !blank && red_lit;
      grn_drv   <= pix_valid && !blank && grn_lit;
      drv_valid <= pix_valid;
    end
  end
endmodule

// File: rtl/tri_dither_chk.sv
module tri_dither_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] pix_code,
  input logic              pix_valid,
  input logic              frame_go,
  input logic              blank,
  input logic              red_drv,
  input logic              grn_drv,
  input logic              drv_valid,
  input logic [1:0]        phase
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> drv_valid == $past(pix_valid));

  // R7
  blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(blank)) |-> (!red_drv && !grn_drv));

  // R9
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(pix_valid)) |-> (!red_drv && !grn_drv));

  // R3
  full_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pix_valid && !blank && pix_code[3:2] == 2'b11)) |-> red_drv);

  // R3
  dark_grn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pix_code[1:0] == 2'b00)) |-> !grn_drv);

  // R4
  third_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pix_valid && !blank && pix_code[3:2] == 2'b01)) |-> red_drv == $past(phase == 2'd0));

  // R5
  two_third_grn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pix_valid && !blank && pix_code[1:0] == 2'b10)) |-> grn_drv == $past(phase != 2'd0));

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(frame_go)) |-> phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(frame_go)) |-> $stable(phase));

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
endmodule

bind tri_dither tri_dither_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_code(pix_code), .pix_valid(pix_valid),
  .frame_go(frame_go), .blank(blank), .red_drv(red_drv), .grn_drv(grn_drv),
  .drv_valid(drv_valid), .phase(phase)
);

// File: tb/tri_dither_test.sv
module tri_dither_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pix_code = '0;
  logic       pix_valid = 1'b0;
  logic       frame_go = 1'b0;
  logic       blank = 1'b0;
  logic       red_drv, grn_drv, drv_valid;

  int checks = 0;
  int fails = 0;
  int mphase = 0;
  int red_cnt, grn_cnt;

  always #5 clk = ~clk;

  tri_dither uut (
    .clk(clk), .rst_n(rst_n), .pix_code(pix_code), .pix_valid(pix_valid),
    .frame_go(frame_go), .blank(blank), .red_drv(red_drv), .grn_drv(grn_drv),
    .drv_valid(drv_valid)
  );

  function automatic bit lvl_on(input int lvl, input int ph);
    case (lvl)
      0: return 1'b0;
      1: return ph == 0;
      2: return ph == 1 || ph == 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] code, input bit v, input bit fg, input bit bl, input string req);
    bit er, eg;
    @(negedge clk);
    pix_code = code; pix_valid = v; frame_go = fg; blank = bl;
    @(posedge clk);
    er = v && !bl && lvl_on(int'(code[3:2]), mphase);
    eg = v && !bl && lvl_on(int'(code[1:0]), mphase);
    if (fg) mphase = (mphase + 1) % 3;
    #1;
    check(req, "drv_valid", drv_valid, v);
    check(req, "red_drv", red_drv, er);
    check(req, "grn_drv", grn_drv, eg);
    red_cnt += red_drv;
    grn_cnt += grn_drv;
  endtask

  task automatic idle();
    step(4'd0, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  task automatic frame(input logic [3:0] code, input bit bl, input string req);
    step(4'd0, 1'b0, 1'b1, bl, "R6");
    step(code, 1'b1, 1'b0, bl, req);
    step(code, 1'b1, 1'b0, bl, req);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1", "red_drv in reset", red_drv, 0);
    check("R1", "grn_drv in reset", grn_drv, 0);
    check("R1", "drv_valid in reset", drv_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1 phase starts at 0: level 01 lit before any frame pulse
    step(4'd5, 1'b1, 1'b0, 1'b0, "R1");
    check("R1", "level01 at phase0", red_drv, 1);

    // R3 full and dark levels across every phase
    for (int f = 0; f < 3; f++) begin
      step(4'd15, 1'b1, 1'b0, 1'b0, "R3");
      step(4'd12, 1'b1, 1'b0, 1'b0, "R3");
      step(4'd3, 1'b1, 1'b0, 1'b0, "R3");
      step(4'd0, 1'b1, 1'b0, 1'b0, "R3");
      step(4'd0, 1'b0, 1'b1, 1'b0, "R6");
    end

    // R4 R5 R6 per-frame tallies over three frames
    for (int code = 0; code < 16; code++) begin
      red_cnt = 0; grn_cnt = 0;
      for (int f = 0; f < 3; f++) begin
        step(4'd0, 1'b0, 1'b1, 1'b0, "R6");
        red_cnt = 0 + red_cnt; grn_cnt = 0 + grn_cnt;
        step(4'(code), 1'b1, 1'b0, 1'b0, "R4");
      end
      check("R6", "red lit frames", red_cnt, (code >> 2) & 3);
      check("R6", "green lit frames", grn_cnt, code & 3);
    end

    // R5 mixed levels
    for (int f = 0; f < 4; f++) frame(4'd9, 1'b0, "R5");
    for (int f = 0; f < 4; f++) frame(4'd6, 1'b0, "R5");

    // R10 pixel with the frame pulse uses the old phase
    for (int f = 0; f < 6; f++) begin
      step(4'd5, 1'b1, 1'b1, 1'b0, "R10");
      step(4'd10, 1'b1, 1'b0, 1'b0, "R10");
    end

    // R9 invalid pixels stay dark
    for (int f = 0; f < 3; f++) begin
      step(4'd15, 1'b0, 1'b0, 1'b0, "R9");
      step(4'd15, 1'b0, 1'b1, 1'b0, "R9");
    end
    idle();

    // R7 blanking with valid data, R8 phase runs on during blanking
    step(4'd15, 1'b1, 1'b0, 1'b1, "R7");
    step(4'd15, 1'b1, 1'b0, 1'b0, "R7");
    frame(4'd15, 1'b1, "R7");
    frame(4'd10, 1'b1, "R8");
    red_cnt = 0; grn_cnt = 0;
    frame(4'd5, 1'b0, "R8");
    frame(4'd5, 1'b0, "R8");
    frame(4'd5, 1'b0, "R8");
    check("R8", "red lit pixels after blank", red_cnt, 2);
    check("R8", "green lit pixels after blank", grn_cnt, 2);
    for (int f = 0; f < 5; f++) begin
      frame(4'd6, (f % 2) == 1, "R8");
      frame(4'd9, 1'b0, "R8");
    end

    // R1 reset returns phase to 0
    @(negedge clk); rst_n = 1'b0; pix_valid = 1'b0; frame_go = 1'b0;
    @(posedge clk); #1;
    check("R1", "drv_valid after re-reset", drv_valid, 0);
    @(negedge clk); rst_n = 1'b1; mphase = 0;
    step(4'd6, 1'b1, 1'b0, 1'b0, "R1");
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule